// File: doc/BRIEF.md
# Monotonic Counter Word Guard

This block protects the lowest 32 bytes of a serial memory. Those bytes hold sixteen 16-bit counters that can only move upwards. The block watches the bit stream that a serial front end delivers while chip select is active. It counts the bits, assembles opcode, address and data, and acts at the moment chip select is released.

A frame is taken only when all of the following hold: it is exactly 40 bits long, it carries the increment-write opcode, its address is even and lies inside the counter area, and the write-enable latch is set. A frame that passes starts a self-timed cycle. At the start of that cycle the block compares the new value with the stored word and records the outcome in a comparison flag. At the end of the cycle it commits the word only if the new value is strictly larger. It then pulses a request to clear the write-enable latch.

No protect pin or block-protect setting reaches this comparison: the monotonic rule always applies. Any counter can be read at any time through an asynchronous read port.

Top module: `incr_word_guard`

## Requirements
- R1: After reset all sixteen counter words read 0x0000, and `wip`, `inc_flag` and `wel_clr` are 0.
- R2: An accepted frame whose 16-bit value is strictly greater than the addressed word replaces that word when the cycle ends.
- R3: A value equal to or lower than the stored word leaves the word unchanged, while the cycle still runs.
- R4: `inc_flag` is loaded in the first cycle of every started write cycle: 1 when the new value is equal or lower, 0 when it is greater. It holds its value at all other times.
- R5: A write cycle starts only when exactly 40 bits (`bit_stb` pulses) were received between the rise and the fall of `cs_act`. 39, 41 or any other count starts nothing.
- R6: Only opcode 0x07 (the first 8 bits, MSB first) starts a cycle. A frame with opcode 0x02, the plain write, changes no counter word.
- R7: Bits 9..24 of the frame are the address, MSB first. Address bit 0 must be 0 and bits 9..5 must be 0, or nothing starts. Bits 15..10 are ignored and bits 4..1 select the word. The last 16 bits are the value, with the high byte first.
- R8: A cycle starts only if `wel_in` is 1 when `cs_act` falls. `wel_clr` pulses for exactly one clock at the end of every started cycle, whether or not the word is committed.
- R9: `wip` rises on the clock after `cs_act` falls and stays high for exactly WR_CYCLES clocks, including for a rejected value. A frame that completes while `wip` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_act | input | 1 | Chip select active level from the front end; its fall ends a frame |
| bit_stb | input | 1 | One-clock strobe per received serial bit |
| bit_val | input | 1 | Value of the strobed bit |
| wel_in | input | 1 | Current write-enable latch state |
| rd_idx | input | 4 | Counter word index for the read port |
| rd_word | output | 16 | Counter word selected by `rd_idx` |
| wip | output | 1 | Self-timed write cycle in progress |
| inc_flag | output | 1 | Comparison result of the latest started cycle |
| wel_clr | output | 1 | One-clock request to clear the write-enable latch |

## Verification
The properties assume that the front end delivers `bit_stb` only while `cs_act` is high, one clock at a time, and that `wel_in` is stable around the fall of `cs_act`. The stimulus drives every input on the falling clock edge and separates strobes with idle clocks. It holds `wel_in` constant for a whole frame and keeps `cs_act` low for at least one rising edge between frames. Random frames mix valid and invalid lengths, random upper address bits, and values above, equal to and below the stored word.

// File: rtl/incr_guard_pkg.sv
package incr_guard_pkg;
  localparam logic [7:0] OPC_INC_WRITE = 8'h07;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_t;
endpackage

// File: rtl/igw_frame_rx.sv
module igw_frame_rx #(
  parameter int OP_W   = 8,
  parameter int ADDR_W = 16,
  parameter int WORD_W = 16,
  parameter int AREA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              bit_stb,
  input  logic              bit_val,
  output logic              rel_pulse,
  output logic              len_ok,
  output logic [OP_W-1:0]   opcode,
  output logic [AREA_W-1:0] area_addr,
  output logic [WORD_W-1:0] data
);
  localparam int FRAME_BITS = OP_W + ADDR_W + WORD_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_EXACT = CNT_W'(FRAME_BITS);

  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic                  cs_q;

  // next state: shift on strobes, saturating count, clear while deselected
  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (!cs_act) begin
      cnt_d = '0;
    end else if (bit_stb) begin
      sh_d = {sh_q[FRAME_BITS-2:0], bit_val};
      if (cnt_q != CNT_SAT) cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      cs_q  <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      cs_q  <= cs_act;
    end
  end

  assign rel_pulse = cs_q & ~cs_act;
  assign len_ok    = (cnt_q == CNT_EXACT);
  assign opcode    = sh_q[FRAME_BITS-1 -: OP_W];
  assign area_addr = sh_q[WORD_W +: AREA_W];
  assign data      = sh_q[WORD_W-1:0];
endmodule

// File: rtl/igw_word_bank.sv
module igw_word_bank #(
  parameter int NUM_WORDS = 16,
  parameter int WORD_W    = 16,
  localparam int IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  cmp_idx,
  output logic [WORD_W-1:0] cmp_word,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] mem_q [NUM_WORDS];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic load;
    assign load = wr_en && (wr_idx == IDX_W'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mem_q[w] <= '0;
      else if (load) mem_q[w] <= wr_data;
    end
  end

  assign cmp_word = mem_q[cmp_idx];
  assign rd_word  = mem_q[rd_idx];
endmodule

// File: rtl/igw_cycle_ctl.sv
module igw_cycle_ctl
  import incr_guard_pkg::*;
#(
  parameter int WR_CYCLES = 32,
  parameter int IDX_W     = 4,
  parameter int WORD_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [IDX_W-1:0]  go_idx,
  input  logic [WORD_W-1:0] go_data,
  input  logic [WORD_W-1:0] old_word,
  output logic [IDX_W-1:0]  cmp_idx,
  output logic              busy,
  output logic              inc,
  output logic              commit,
  output logic [IDX_W-1:0]  commit_idx,
  output logic [WORD_W-1:0] commit_data,
  output logic              wel_clr
);
  localparam int TMR_W = $clog2(WR_CYCLES + 1);

  seq_state_t        st_q, st_d;
  logic [TMR_W-1:0]  tmr_q, tmr_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] dat_q, dat_d;
  logic              grt_q, grt_d;
  logic              inc_q, inc_d;
  logic              larger;
  logic              last;

  assign larger = go_data > old_word;
  assign busy   = (st_q == SEQ_BUSY);
  assign last   = busy && (tmr_q == '0);

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q;
    idx_d = idx_q;
    dat_d = dat_q;
    grt_d = grt_q;
    inc_d = inc_q;
    case (st_q)
      SEQ_IDLE: if (go) begin
        st_d  = SEQ_BUSY;
        tmr_d = TMR_W'(WR_CYCLES - 1);
        idx_d = go_idx;
        dat_d = go_data;
        grt_d = larger;
        inc_d = ~larger;
      end
      SEQ_BUSY: begin
        if (tmr_q == '0) st_d = SEQ_IDLE;
        else             tmr_d = tmr_q - TMR_W'(1);
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      tmr_q <= '0;
      idx_q <= '0;
      dat_q <= '0;
      grt_q <= 1'b0;
      inc_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
      idx_q <= idx_d;
      dat_q <= dat_d;
      grt_q <= grt_d;
      inc_q <= inc_d;
    end
  end

  assign cmp_idx     = busy ? idx_q : go_idx;
  assign inc         = inc_q;
  assign commit      = last && grt_q;
  assign commit_idx  = idx_q;
  assign commit_data = dat_q;
  assign wel_clr     = last;
endmodule

// File: rtl/incr_word_guard.sv
module incr_word_guard
  import incr_guard_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  parameter int WORD_W    = 16,
  parameter int OP_W      = 8,
  parameter int ADDR_W    = 16,
  parameter int AREA_W    = 10,
  parameter int WR_CYCLES = 32,
  localparam int IDX_W    = $clog2(NUM_WORDS),
  localparam int BYTE_W   = $clog2(NUM_WORDS * WORD_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic              wel_in,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word,
  output logic              wip,
  output logic              inc_flag,
  output logic              wel_clr
);
  logic              rel_pulse;
  logic              len_ok;
  logic [OP_W-1:0]   opcode;
  logic [AREA_W-1:0] area_addr;
  logic [WORD_W-1:0] data;
  logic              addr_ok;
  logic              go;
  logic [IDX_W-1:0]  cmp_idx;
  logic [WORD_W-1:0] cmp_word;
  logic              commit;
  logic [IDX_W-1:0]  commit_idx;
  logic [WORD_W-1:0] commit_data;

  igw_frame_rx #(
    .OP_W(OP_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W), .AREA_W(AREA_W)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .bit_stb(bit_stb),
    .bit_val(bit_val), .rel_pulse(rel_pulse), .len_ok(len_ok),
    .opcode(opcode), .area_addr(area_addr), .data(data)
  );

  // even address, inside the counter area; upper address bits are not looked at
  assign addr_ok = (area_addr[0] == 1'b0) && (area_addr[AREA_W-1:BYTE_W] == '0);
  assign go      = rel_pulse && len_ok && (opcode == OPC_INC_WRITE) && addr_ok && wel_in;

  igw_cycle_ctl #(
    .WR_CYCLES(WR_CYCLES), .IDX_W(IDX_W), .WORD_W(WORD_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .go_idx(area_addr[IDX_W:1]),
    .go_data(data), .old_word(cmp_word), .cmp_idx(cmp_idx), .busy(wip),
    .inc(inc_flag), .commit(commit), .commit_idx(commit_idx),
    .commit_data(commit_data), .wel_clr(wel_clr)
  );

  igw_word_bank #(
    .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(commit), .wr_idx(commit_idx),
    .wr_data(commit_data), .cmp_idx(cmp_idx), .cmp_word(cmp_word),
    .rd_idx(rd_idx), .rd_word(rd_word)
  );
endmodule

// File: rtl/igw_checker.sv
module igw_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wip,
  input logic              inc_flag,
  input logic              wel_clr,
  input logic              wel_in,
  input logic              rel,
  input logic              len_ok,
  input logic              commit,
  input logic [WORD_W-1:0] commit_data,
  input logic [WORD_W-1:0] old_word
);
  p_commit_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (commit_data > old_word));

  p_inc_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(inc_flag) |-> $rose(wip));

  p_start_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(rel && len_ok));

  p_start_wel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(wel_in));

  p_clr_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !wip);

  p_commit_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (wip && wel_clr));
endmodule

bind incr_word_guard igw_checker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wip(wip), .inc_flag(inc_flag),
  .wel_clr(wel_clr), .wel_in(wel_in), .rel(rel_pulse), .len_ok(len_ok),
  .commit(commit), .commit_data(commit_data), .old_word(cmp_word)
);

// File: tb/incr_word_guard_bench.sv
module incr_word_guard_bench;
  localparam int WRC = 100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_act, bit_stb, bit_val, wel_in;
  logic [3:0]  rd_idx;
  logic [15:0] rd_word;
  logic        wip, inc_flag, wel_clr;

  int checks = 0;
  int fails  = 0;
  logic [15:0] mdl [16];
  logic        mdl_inc;

  always #5 clk = ~clk;

  incr_word_guard #(.WR_CYCLES(WRC)) u_incr_word_guard (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .bit_stb(bit_stb),
    .bit_val(bit_val), .wel_in(wel_in), .rd_idx(rd_idx), .rd_word(rd_word),
    .wip(wip), .inc_flag(inc_flag), .wel_clr(wel_clr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit will_start(input logic [7:0] op, input logic [15:0] a,
                                    input int nb, input bit w);
    return (nb == 40) && (op == 8'h07) && (a[0] == 1'b0) && (a[9:5] == 5'd0) && w;
  endfunction

  task automatic send(input logic [7:0] op, input logic [15:0] a, input logic [15:0] v,
                      input int nb, input bit w);
    logic [47:0] vec;
    vec = {op, a, v, 8'h5A};
    @(negedge clk);
    wel_in = w;
    cs_act = 1'b1;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      bit_stb = 1'b1;
      bit_val = vec[47-i];
      @(negedge clk);
      bit_stb = 1'b0;
    end
    @(negedge clk);
    cs_act = 1'b0;
  endtask

  task automatic measure(output int busy_n, output int clr_n);
    int guard = 0;
    busy_n = 0;
    clr_n  = 0;
    @(negedge clk);
    while (wip && guard < 100000) begin
      busy_n++;
      if (wel_clr) clr_n++;
      guard++;
      @(negedge clk);
    end
  endtask

  task automatic read_word(input int idx, output logic [15:0] w);
    rd_idx = 4'(idx);
    #1;
    w = rd_word;
  endtask

  // full frame, model update and checks of cycle length, latch clear, flag and word
  task automatic frame(input logic [7:0] op, input logic [15:0] a, input logic [15:0] v,
                       input int nb, input bit w, input string tag);
    bit st;
    int bn, cn, ix;
    logic [15:0] got;
    st = will_start(op, a, nb, w);
    ix = int'(a[4:1]);
    send(op, a, v, nb, w);
    measure(bn, cn);
    if (st) begin
      mdl_inc = !(v > mdl[ix]);
      if (v > mdl[ix]) mdl[ix] = v;
    end
    check(bn == (st ? WRC : 0), {tag, " R9 wip length"}, bn, st ? WRC : 0);
    check(cn == (st ? 1 : 0), {tag, " R8 latch clear"}, cn, st ? 1 : 0);
    check(inc_flag == mdl_inc, {tag, " R4 flag"}, inc_flag, mdl_inc);
    read_word(ix, got);
    check(got == mdl[ix], {tag, " word"}, got, mdl[ix]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] w;
    int bn, cn;
    void'($urandom(32'd4242));
    rst_n = 1'b0; cs_act = 1'b0; bit_stb = 1'b0; bit_val = 1'b0;
    wel_in = 1'b0; rd_idx = '0;
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    mdl_inc = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 16; i++) begin
      read_word(i, w);
      check(w == 16'h0, "R1 word reset", w, 0);
    end
    check(!wip && !inc_flag && !wel_clr, "R1 outputs reset", {wip, inc_flag, wel_clr}, 0);

    // R2 R3 R4 basic ordering
    frame(8'h07, 16'h0006, 16'h1234, 40, 1, "R2 accept");
    frame(8'h07, 16'h0006, 16'h1234, 40, 1, "R3 equal");
    frame(8'h07, 16'h0006, 16'h1000, 40, 1, "R3 lower");
    frame(8'h07, 16'h0006, 16'h1235, 40, 1, "R2 plus one");
    // R5 length
    frame(8'h07, 16'h0006, 16'h4000, 39, 1, "R5 short");
    frame(8'h07, 16'h0006, 16'h4000, 41, 1, "R5 long");
    frame(8'h07, 16'h0006, 16'h4000, 48, 1, "R5 six bytes");
    // R6 plain write opcode
    frame(8'h02, 16'h0008, 16'h5555, 40, 1, "R6 plain write");
    frame(8'h02, 16'h0008, 16'h5555, 32, 1, "R6 plain byte");
    // R7 address rules and byte order
    frame(8'h07, 16'h0009, 16'h7777, 40, 1, "R7 odd");
    frame(8'h07, 16'h0028, 16'h7777, 40, 1, "R7 outside area");
    frame(8'h07, 16'hFC0A, 16'hAB01, 40, 1, "R7 upper bits ignored");
    frame(8'h07, 16'h001E, 16'h00FF, 40, 1, "R7 last word");
    // R8 latch
    frame(8'h07, 16'h0002, 16'h0100, 40, 0, "R8 latch clear");
    // top value
    frame(8'h07, 16'h0004, 16'hFFFF, 40, 1, "R2 top");
    frame(8'h07, 16'h0004, 16'hFFFF, 40, 1, "R3 top again");

    // R9 frame completing during a busy cycle is dropped
    send(8'h07, 16'h000C, 16'h0100, 40, 1);
    send(8'h07, 16'h000E, 16'h0200, 40, 1);
    check(wip == 1'b1, "R9 still busy", wip, 1);
    mdl[6] = 16'h0100; mdl_inc = 1'b0;
    measure(bn, cn);
    read_word(6, w);
    check(w == 16'h0100, "R9 first frame kept", w, 16'h0100);
    read_word(7, w);
    check(w == 16'h0000, "R9 overlapped frame dropped", w, 0);
    check(inc_flag == 1'b0, "R9 R4 flag after overlap", inc_flag, 0);

    // random mix
    for (int n = 0; n < 70; n++) begin
      int ix, k, nb;
      logic [15:0] v, a;
      bit wl;
      ix = $urandom_range(0, 15);
      k  = $urandom_range(0, 9);
      if (k < 5)      v = mdl[ix] + 16'($urandom_range(1, 300));
      else if (k < 7) v = mdl[ix] - 16'($urandom_range(0, 300));
      else            v = 16'($urandom);
      nb = (k == 9) ? ($urandom_range(0, 1) ? 39 : 41) : 40;
      wl = ($urandom_range(0, 7) != 0);
      a  = {6'($urandom), 5'd0, 4'(ix), 1'b0};
      frame(8'h07, a, v, nb, wl, "R2 R3 R5 random");
    end

    for (int i = 0; i < 16; i++) begin
      read_word(i, w);
      check(w == mdl[i], "R2 final sweep", w, mdl[i]);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule